// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Handshake-Cleared Status Flags

The block is one 16-bit timer channel. A free-running up-counter advances by one on every clock in which the count-enable input is high. Two general registers sit beside the counter. A per-register mode bit sets each one to work in one of two ways. In capture mode, the register latches the counter when a synchronised rising edge arrives on its capture pin. In compare mode, the register raises a match each time the counter steps onto its value.

A status register holds three flags: one per general register, plus a counter overflow flag. A flag sets on its event. It clears only through a two-step handshake: software first reads the status register while the flag is 1, and then writes 0 to that bit. Per-flag enable bits gate the flags onto a single interrupt request output.

Software reaches the counter, both general registers, the mode bits, the status register and the enables through a word-wide bus with single-cycle access. Reads are combinational.

Top module: `tmr_cc_channel`

## Requirements
- R1: After reset the following all read 0: the counter, both general registers, the mode bits, all status flags and the interrupt enables. `irq` is low.
- R2: The counter sits at address 0. It increments by one at each clock edge where `cnt_tick` is 1 and holds otherwise. A bus write to address 0 loads it, takes priority over the tick, and produces neither an overflow nor a compare event.
- R3: The overflow flag is status bit 2. It sets at the edge where an increment takes the counter from 0xFFFF to 0x0000.
- R4: General register g (A at address 1, B at address 2) is in compare mode when mode bit g (address 3) is 0. In that mode, status bit g sets at the same edge where an increment brings the counter to the register's value. An unchanging equality with no increment does not set it again.
- R5: A general register is in capture mode when its mode bit is 1. A capture input passes through two synchroniser stages before a rising-edge detector. At the edge two clocks after the first edge that samples the input high, the register takes the counter value held before that edge, and status bit g sets. A capture wins over a bus write to the same register in that cycle.
- R6: A status read (address 4) that returns a flag as 1 arms that flag. A following status write with that bit 0 clears the flag and consumes its arm.
- R7: Writing 0 to a flag that has not been armed leaves it set, and this write also discards no arm. Writing 1 to a flag bit never changes that flag.
- R8: If a flag's set event falls in the same cycle as a valid clearing write, the flag stays 1.
- R9: The three flags set and clear independently of one another.
- R10: The interrupt enables are at address 5, one bit per status bit in the same positions. `irq` is the OR of the flags whose enable is 1.
- R11: `bus_rdata` shows the addressed register only while `bus_sel` is 1 and `bus_wr` is 0. It is 0 otherwise, and also for unused addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter increment enable |
| cap_in | input | 2 | Capture pins, bit 0 for register A, bit 1 for register B |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the race in R8. A flag must be set and already armed by a read. Then, in the single cycle of the clearing write, its set event has to fire again. For a compare flag, this means holding the tick low, reloading the counter to one below the register value, reading the status, and only then enabling the tick together with the zero write. A directed sequence builds exactly that case for compare. A long seeded random run adds capture pulses, stray zero writes and status reads, so the same collision also occurs for capture and overflow, with every read checked against an independent bench model.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic {
    GR_COMPARE = 1'b0,
    GR_CAPTURE = 1'b1
  } gr_mode_e;

  localparam int TCC_DEF_CNT_W = 16;
endpackage

// File: rtl/tcc_capture_sync.sv
module tcc_capture_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[DEPTH-2:0], din};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/tcc_flag_cell.sv
module tcc_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic wr_bit,
  output logic flag,
  output logic armed
);
  logic zero_wr;
  logic clr_ok;

  assign zero_wr = stat_wr & ~wr_bit;
  assign clr_ok  = zero_wr & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (set_evt)     flag <= 1'b1;
      else if (clr_ok) flag <= 1'b0;
      if (zero_wr)             armed <= 1'b0;
      else if (stat_rd && flag) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_cc_channel.sv
module tmr_cc_channel #(
  parameter int CNT_W = tcc_pkg::TCC_DEF_CNT_W,
  parameter int NUM_GR = 2,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(NUM_GR + 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_tick,
  input  logic [NUM_GR-1:0] cap_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  import tcc_pkg::*;

  localparam int NF     = NUM_GR + 1;
  localparam int OVF    = NUM_GR;
  localparam int A_CNT  = 0;
  localparam int A_MODE = NUM_GR + 1;
  localparam int A_STAT = NUM_GR + 2;
  localparam int A_IEN  = NUM_GR + 3;

  function automatic logic [CNT_W:0] count_step(input logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic rd_acc, wr_acc, wr_cnt, stat_rd, stat_wr;
  logic step, carry, ovf_evt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [NUM_GR-1:0][CNT_W-1:0] gr_q;
  logic [NUM_GR-1:0] mode_q, cap_rise, cap_evt, cmp_evt;
  logic [NF-1:0] ien_q, set_evt, flags, arm;
  logic [CNT_W-1:0] rd_mux;

  assign rd_acc  = bus_sel & ~bus_wr;
  assign wr_acc  = bus_sel & bus_wr;
  assign wr_cnt  = wr_acc & (bus_addr == ADDR_W'(A_CNT));
  assign stat_rd = rd_acc & (bus_addr == ADDR_W'(A_STAT));
  assign stat_wr = wr_acc & (bus_addr == ADDR_W'(A_STAT));

  assign step              = cnt_tick & ~wr_cnt;
  assign {carry, cnt_nxt}  = count_step(cnt_q);
  assign ovf_evt           = step & carry;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (step)   cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= '0;
    end else if (wr_acc) begin
      if (bus_addr == ADDR_W'(A_MODE)) mode_q <= bus_wdata[NUM_GR-1:0];
      if (bus_addr == ADDR_W'(A_IEN))  ien_q  <= bus_wdata[NF-1:0];
    end
  end

  for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
    tcc_capture_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cap_in[g]),
      .rise (cap_rise[g])
    );

    assign cap_evt[g] = (gr_mode_e'(mode_q[g]) == GR_CAPTURE) & cap_rise[g];
    assign cmp_evt[g] = (gr_mode_e'(mode_q[g]) == GR_COMPARE) & step &
                        (cnt_nxt == gr_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n)
        gr_q[g] <= '0;
      else if (cap_evt[g])
        gr_q[g] <= cnt_q;
      else if (wr_acc && bus_addr == ADDR_W'(g + 1))
        gr_q[g] <= bus_wdata;
    end
  end

  assign set_evt = {ovf_evt, cap_evt | cmp_evt};

  for (genvar f = 0; f < NF; f++) begin : g_flag
    tcc_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(set_evt[f]),
      .stat_rd(stat_rd),
      .stat_wr(stat_wr),
      .wr_bit (bus_wdata[f]),
      .flag   (flags[f]),
      .armed  (arm[f])
    );
  end

  assign irq = |(flags & ien_q);

  always_comb begin
    rd_mux = '0;
    if (rd_acc) begin
      if (bus_addr == ADDR_W'(A_CNT))  rd_mux = cnt_q;
      if (bus_addr == ADDR_W'(A_MODE)) rd_mux[NUM_GR-1:0] = mode_q;
      if (bus_addr == ADDR_W'(A_STAT)) rd_mux[NF-1:0] = flags;
      if (bus_addr == ADDR_W'(A_IEN))  rd_mux[NF-1:0] = ien_q;
      for (int g = 0; g < NUM_GR; g++)
        if (bus_addr == ADDR_W'(g + 1)) rd_mux = gr_q[g];
    end
  end

  assign bus_rdata = rd_mux;

  localparam int UNUSED_OVF = OVF;
endmodule

// File: rtl/tmr_cc_channel_chk.sv
module tmr_cc_channel_chk #(
  parameter int CNT_W = 16,
  parameter int NUM_GR = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           ovf_evt,
  input logic                           stat_wr,
  input logic [CNT_W-1:0]               bus_wdata,
  input logic [NUM_GR:0]                set_evt,
  input logic [NUM_GR:0]                flags,
  input logic [NUM_GR:0]                arm,
  input logic [NUM_GR-1:0]              cap_evt,
  input logic [CNT_W-1:0]               cnt_q,
  input logic [NUM_GR-1:0][CNT_W-1:0]   gr_q
);
  // R3
  ovf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[NUM_GR]);

  for (genvar f = 0; f <= NUM_GR; f++) begin : g_fchk
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[f] |=> flags[f]);
    // R7
    no_blind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && !bus_wdata[f] && !arm[f] && flags[f]) |=> flags[f]);
    // R6
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[f]) |-> $past(stat_wr && !bus_wdata[f] && arm[f]));
    // R9
    rise_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[f]) |-> $past(set_evt[f]));
  end

  for (genvar g = 0; g < NUM_GR; g++) begin : g_cchk
    // R5
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[g] |=> (gr_q[g] == $past(cnt_q)));
  end
endmodule

bind tmr_cc_channel tmr_cc_channel_chk #(.CNT_W(CNT_W), .NUM_GR(NUM_GR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ovf_evt  (ovf_evt),
  .stat_wr  (stat_wr),
  .bus_wdata(bus_wdata),
  .set_evt  (set_evt),
  .flags    (flags),
  .arm      (arm),
  .cap_evt  (cap_evt),
  .cnt_q    (cnt_q),
  .gr_q     (gr_q)
);

// File: tb/tmr_cc_channel_tb.sv
module tmr_cc_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  cap = 2'b00;
  logic        b_sel = 1'b0, b_wr = 1'b0;
  logic [2:0]  b_addr = '0;
  logic [15:0] b_wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmr_cc_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(tick), .cap_in(cap),
    .bus_sel(b_sel), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .irq(irq)
  );

  // Bench model built from the requirements
  logic [15:0] m_cnt;
  logic [15:0] m_gr [2];
  logic [1:0]  m_mode;
  logic [2:0]  m_en, m_flag, m_arm;
  logic [2:0]  m_sy [2];

  always @(posedge clk) begin
    logic wrc, stp, wst, rst_s, rise;
    logic [15:0] nxt;
    logic [2:0] ev, nf, na;
    if (!rst_n) begin
      m_cnt = 0; m_gr[0] = 0; m_gr[1] = 0; m_mode = 0; m_en = 0;
      m_flag = 0; m_arm = 0; m_sy[0] = 0; m_sy[1] = 0;
    end else begin
      wrc   = b_sel && b_wr && b_addr == 3'd0;
      wst   = b_sel && b_wr && b_addr == 3'd4;
      rst_s = b_sel && !b_wr && b_addr == 3'd4;
      stp   = tick && !wrc;
      nxt   = m_cnt + 16'd1;
      ev    = '0;
      ev[2] = stp && m_cnt == 16'hFFFF;
      for (int g = 0; g < 2; g++) begin
        rise  = m_sy[g][1] && !m_sy[g][2];
        ev[g] = m_mode[g] ? rise : (stp && nxt == m_gr[g]);
        if (m_mode[g] && rise) m_gr[g] = m_cnt;
        else if (b_sel && b_wr && b_addr == 3'(g + 1)) m_gr[g] = b_wdata;
        m_sy[g] = {m_sy[g][1:0], cap[g]};
      end
      for (int f = 0; f < 3; f++) begin
        nf[f] = ev[f] ? 1'b1 : ((wst && !b_wdata[f] && m_arm[f]) ? 1'b0 : m_flag[f]);
        na[f] = (wst && !b_wdata[f]) ? 1'b0 : ((rst_s && m_flag[f]) ? 1'b1 : m_arm[f]);
      end
      m_flag = nf; m_arm = na;
      if (wrc) m_cnt = b_wdata; else if (stp) m_cnt = nxt;
      if (b_sel && b_wr && b_addr == 3'd3) m_mode = b_wdata[1:0];
      if (b_sel && b_wr && b_addr == 3'd5) m_en = b_wdata[2:0];
    end
  end

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_gr[0];
      3'd2: return m_gr[1];
      3'd3: return {14'd0, m_mode};
      3'd4: return {13'd0, m_flag};
      3'd5: return {13'd0, m_en};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1, 3'd2: return "R4/R5";
      3'd3: return "R11";
      3'd4: return "R6/R9";
      3'd5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h at %0t", req, act, expv, $time);
    end
  endtask

  // one bus cycle; lbl overrides the requirement tag of the read check
  task automatic cyc(input logic s, input logic w, input logic [2:0] a,
                     input logic [15:0] d, input logic t, input logic [1:0] c,
                     input string lbl);
    @(negedge clk);
    check("R10", {15'd0, irq}, {15'd0, |(m_flag & m_en)});
    b_sel = s; b_wr = w; b_addr = a; b_wdata = d; tick = t; cap = c;
    #1;
    if (s && !w) check(lbl != "" ? lbl : req_of(a), rdata, exp_rd(a));
    else check("R11", rdata, 16'd0);
    @(posedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cyc(1, 1, a, d, 0, 0, "");
  endtask

  task automatic rd(input logic [2:0] a, input string lbl);
    cyc(1, 0, a, 0, 0, 0, lbl);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      b_sel = 1; b_wr = 0; b_addr = 3'(a); #1;
      check("R1", rdata, 16'd0);
    end
    check("R1", {15'd0, irq}, 16'd0);
    // R2 counting and load priority
    repeat (5) cyc(0, 0, 0, 0, 1, 0, "");
    rd(0, "R2");
    check("R2", m_cnt, 16'd5);
    cyc(1, 1, 0, 16'h1234, 1, 0, "");
    rd(0, "R2");
    // R3 overflow wrap
    wr(0, 16'hFFFF);
    cyc(0, 0, 0, 0, 1, 0, "");
    rd(4, "R3");
    rd(0, "R3");
    // R7 blind zero write and write of one leave the flag
    wr(4, 16'h0000); // arm was consumed above? read armed it, so this clears
    rd(4, "R6");
    wr(0, 16'hFFFF);
    cyc(0, 0, 0, 0, 1, 0, "");
    wr(4, 16'h0000);
    rd(4, "R7");
    wr(4, 16'h0007);
    rd(4, "R7");
    wr(4, 16'h0000);
    rd(4, "R6");
    // R8 compare set colliding with the clearing write
    wr(5, 16'h0001);
    wr(1, 16'h0100);
    wr(0, 16'h00FF);
    cyc(0, 0, 0, 0, 1, 0, "");
    rd(4, "R4");
    wr(0, 16'h00FF);
    rd(4, "R8");
    cyc(1, 1, 4, 16'h0000, 1, 0, "");
    rd(4, "R8");
    // R4 static equality does not re-set
    rd(4, "R4");
    wr(4, 16'h0000);
    repeat (3) cyc(0, 0, 0, 0, 0, 0, "");
    rd(4, "R4");
    // R5 capture on B, R9 independence
    wr(3, 16'h0002);
    wr(0, 16'h0040);
    cyc(0, 0, 0, 0, 1, 2'b10, "");
    repeat (4) cyc(0, 0, 0, 0, 1, 2'b10, "");
    rd(2, "R5");
    rd(4, "R9");
    cyc(0, 0, 0, 0, 0, 2'b00, "");
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int op = $urandom_range(0, 99);
      logic t = ($urandom_range(0, 9) < 7);
      logic [1:0] c = 2'($urandom_range(0, 3)) & {2{$urandom_range(0, 3) == 0}};
      if (op < 35)      cyc(0, 0, 0, 0, t, c, "");
      else if (op < 65) cyc(1, 0, 3'($urandom_range(0, 7)), 0, t, c, "");
      else if (op < 80) cyc(1, 1, 4, 16'($urandom_range(0, 7)), t, c, "");
      else if (op < 85) cyc(1, 1, 3, 16'($urandom_range(0, 3)), t, c, "");
      else if (op < 90) cyc(1, 1, 5, 16'($urandom_range(0, 7)), t, c, "");
      else if (op < 96) cyc(1, 1, 3'($urandom_range(1, 2)), 16'($urandom), t, c, "");
      else cyc(1, 1, 0, ($urandom_range(0, 1) == 1) ? 16'hFFFE : 16'($urandom), t, c, "");
    end
    for (int a = 0; a < 6; a++) rd(3'(a), "");
    finish_run();
  end
endmodule